// File: doc/BRIEF.md
# Decode Stage with Operand Forwarding

This block is the second stage of a four-stage integer pipeline: fetch, decode with operand read, execute, write back. Each cycle it takes one 24-bit instruction word from fetch. It sends the two 3-bit source register numbers straight to the register file, so the operands are ready when the instruction reaches execute. It also resolves branches at once against the status flags and gives fetch a branch select and a target. On the rising clock edge it loads the execute-stage controls: the ALU opcode, the 10-bit immediate or address field, the destination register, the register write enable and the data memory write enable.

Back-to-back dependent instructions run without a stall. The stage compares the destination of the instruction now in execute with the two source fields of the instruction being decoded. On a match it registers a per-side forward select. The execute stage then feeds the previous ALU result into that ALU input in place of the stale register file value. A dependency two instructions apart is not forwarded; the register file must pass a value written in the same cycle through to its read port. Control hazards are not handled in hardware: code places NOPs ahead of every jump.

The instruction word is laid out as follows. Bits [23:16] hold the opcode. Bits [15:13] hold the A field, which is the destination and first source. Bits [12:10] hold the B field, the second source. Bits [9:0] hold the immediate or address. Registers R0 to R7 are encoded 000 to 111. The status flags input carries carry in bit 0, zero in bit 1 and parity in bit 2.

Top module: `dec_fwd_stage`

## Requirements
- R1: `rd_addr_a_o` equals instruction bits [15:13] and `rd_addr_b_o` equals bits [12:10], combinationally, for every opcode.
- R2: An opcode in 01..19 hex other than 0F (this includes LOAD 0E, MOV 10, MVI 11 and the arithmetic, logic and shift group) sets `ex_reg_we_o` on the next rising edge, with `ex_wr_addr_o` equal to the A field.
- R3: STORE (0F) sets `ex_ram_we_o` and clears `ex_reg_we_o` on the next edge. No other opcode sets `ex_ram_we_o`.
- R4: NOP (00), the branches (1A..1F, 21) and every undefined opcode (20, 22..FF) clear both write enables on the next edge. Undefined opcodes load `ex_alu_op_o` with 00. Every defined opcode loads its own value.
- R5: `ex_imm_o` takes instruction bits [9:0] on the next edge.
- R6: `ex_fwd_a_o` is set on the next edge exactly when the instruction in execute has `ex_reg_we_o` set and `ex_wr_addr_o` equals the current A field.
- R7: `ex_fwd_b_o` is set on the next edge exactly when the instruction in execute has `ex_reg_we_o` set and `ex_wr_addr_o` equals the current B field.
- R8: An instruction in execute with `ex_reg_we_o` clear (STORE, NOP, branch, undefined) never causes a forward select, whatever its A field holds.
- R9: JMP (21) drives `br_sel_o` high unconditionally. Whenever `br_sel_o` is high, `br_addr_o` equals instruction bits [9:0].
- R10: The conditional branches are taken when a flag is set or clear, as follows: JC 1A when carry is set, JNC 1B when carry is clear, JP 1C when parity is set, JNP 1D when parity is clear, JZ 1E when zero is set, JNZ 1F when zero is clear. No other opcode drives `br_sel_o`.
- R11: While `rst_n` is low, a rising edge loads the NOP state: every execute-stage output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_i | input | 24 | Instruction word in decode |
| flags_i | input | 3 | Status flags: [0] carry, [1] zero, [2] parity |
| rd_addr_a_o | output | 3 | Register file read address, A side |
| rd_addr_b_o | output | 3 | Register file read address, B side |
| br_sel_o | output | 1 | Fetch takes the branch target |
| br_addr_o | output | 10 | Branch target address |
| ex_alu_op_o | output | 8 | ALU opcode in execute |
| ex_imm_o | output | 10 | Immediate or address field in execute |
| ex_wr_addr_o | output | 3 | Destination register of the instruction in execute |
| ex_reg_we_o | output | 1 | Register write enable carried to write back |
| ex_ram_we_o | output | 1 | Data memory write enable |
| ex_fwd_a_o | output | 1 | A-side ALU input takes the previous ALU result |
| ex_fwd_b_o | output | 1 | B-side ALU input takes the previous ALU result |

## Verification
The opcode sweep drives all 256 opcodes against all eight flag combinations. It separates the register-writing group, the memory store, the defined non-writing opcodes and the undefined space, and it shows every branch condition resolving against the correct flag bit and polarity. The forwarding sweep pairs a writing or a storing instruction, for every destination, with every A and B source combination. It shows that a match on either side is detected on its own, that both sides can fire together, and that a non-writer never forwards. A short dependent program runs through a register file and ALU model in the bench. It shows that the forward selects give correct results for distance-one dependencies, and that distance-two dependencies rely on the same-cycle write bypass instead.

// File: rtl/dec_pkg.sv
// Shared constants for the decode stage: instruction field layout,
// opcode values and status flag bit positions.
// Assumes a 24-bit word: opcode, A field, B field, immediate/address.
package dec_pkg;
    localparam int OP_W     = 8;
    localparam int REG_AW   = 3;
    localparam int FIELD_W  = 10;
    localparam int FLAG_W   = 3;
    localparam int NUM_SRC  = 2;
    localparam int INSTR_W  = OP_W + NUM_SRC * REG_AW + FIELD_W;
    localparam int OP_LSB   = INSTR_W - OP_W;
    localparam int SRCA_LSB = OP_LSB - REG_AW;
    localparam int SRCB_LSB = SRCA_LSB - REG_AW;

    localparam logic [OP_W-1:0] OP_NOP      = 8'h00;
    localparam logic [OP_W-1:0] OP_FIRST_WR = 8'h01;
    localparam logic [OP_W-1:0] OP_STORE    = 8'h0F;
    localparam logic [OP_W-1:0] OP_LAST_WR  = 8'h19;
    localparam logic [OP_W-1:0] OP_JC       = 8'h1A;
    localparam logic [OP_W-1:0] OP_JNC      = 8'h1B;
    localparam logic [OP_W-1:0] OP_JP       = 8'h1C;
    localparam logic [OP_W-1:0] OP_JNP      = 8'h1D;
    localparam logic [OP_W-1:0] OP_JZ       = 8'h1E;
    localparam logic [OP_W-1:0] OP_JNZ      = 8'h1F;
    localparam logic [OP_W-1:0] OP_JMP      = 8'h21;

    localparam int FLG_CARRY  = 0;
    localparam int FLG_ZERO   = 1;
    localparam int FLG_PARITY = 2;

    // Controls carried from decode into execute.
    typedef struct packed {
        logic [OP_W-1:0]    alu_op;
        logic [FIELD_W-1:0] imm;
        logic [REG_AW-1:0]  wr_addr;
        logic               reg_we;
        logic               ram_we;
    } ex_ctrl_t;
endpackage

// File: rtl/dec_ctrl.sv
// Opcode classifier. Tells whether the opcode writes a register, writes
// data memory, or is defined at all. Purely combinational; the caller
// registers the results into the execute stage.
module dec_ctrl
    import dec_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output logic            reg_we_o,
    output logic            ram_we_o,
    output logic            valid_o
);
    // Classify the opcode into write classes and the defined space.
    always_comb begin
        reg_we_o = (op_i >= OP_FIRST_WR) && (op_i <= OP_LAST_WR) && (op_i != OP_STORE);
        ram_we_o = (op_i == OP_STORE);
        valid_o  = (op_i <= OP_JNZ) || (op_i == OP_JMP);
    end
endmodule

// File: rtl/dec_branch.sv
// Branch resolver. Decides whether fetch must take the target in the
// address field. Assumes flags are already settled, which the NOPs that
// code places ahead of each jump guarantee.
module dec_branch
    import dec_pkg::*;
(
    input  logic [OP_W-1:0]   op_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              taken_o
);
    // Pick the flag and polarity for each branch opcode.
    always_comb begin
        unique case (op_i)
            OP_JMP:  taken_o = 1'b1;
            OP_JC:   taken_o =  flags_i[FLG_CARRY];
            OP_JNC:  taken_o = ~flags_i[FLG_CARRY];
            OP_JP:   taken_o =  flags_i[FLG_PARITY];
            OP_JNP:  taken_o = ~flags_i[FLG_PARITY];
            OP_JZ:   taken_o =  flags_i[FLG_ZERO];
            OP_JNZ:  taken_o = ~flags_i[FLG_ZERO];
            default: taken_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/dec_hazard.sv
// Forwarding detector. Compares the destination of the instruction in
// execute with each source field in decode, one comparator per side.
// Assumes the execute-stage enable already excludes non-writers.
module dec_hazard
    import dec_pkg::*;
#(
    parameter int SRCS = NUM_SRC
) (
    input  logic                        ex_we_i,
    input  logic [REG_AW-1:0]           ex_wa_i,
    input  logic [SRCS-1:0][REG_AW-1:0] src_i,
    output logic [SRCS-1:0]             fwd_o
);
    for (genvar g = 0; g < SRCS; g++) begin : g_side
        // Flag a side whose source is written by the instruction in execute.
        always_comb fwd_o[g] = ex_we_i && (ex_wa_i == src_i[g]);
    end
endmodule

// File: rtl/dec_fwd_stage.sv
// Decode and operand-fetch stage. Drives the register file read
// addresses and the branch select combinationally, and registers the
// execute controls and forward selects on the rising edge.
// Assumes the register file passes a same-cycle write to its read port,
// and that NOPs sit ahead of jumps (no flush here).
module dec_fwd_stage
    import dec_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [INSTR_W-1:0]  instr_i,
    input  logic [FLAG_W-1:0]   flags_i,
    output logic [REG_AW-1:0]   rd_addr_a_o,
    output logic [REG_AW-1:0]   rd_addr_b_o,
    output logic                br_sel_o,
    output logic [FIELD_W-1:0]  br_addr_o,
    output logic [OP_W-1:0]     ex_alu_op_o,
    output logic [FIELD_W-1:0]  ex_imm_o,
    output logic [REG_AW-1:0]   ex_wr_addr_o,
    output logic                ex_reg_we_o,
    output logic                ex_ram_we_o,
    output logic                ex_fwd_a_o,
    output logic                ex_fwd_b_o
);
    logic [OP_W-1:0]              op;
    logic [FIELD_W-1:0]           field;
    logic [NUM_SRC-1:0][REG_AW-1:0] srcs;
    logic                         c_reg_we, c_ram_we, c_valid;
    logic [NUM_SRC-1:0]           fwd_nxt;
    ex_ctrl_t                     ctl_nxt, ctl_q;
    logic [NUM_SRC-1:0]           fwd_q;

    // Split the instruction word into its fields.
    always_comb begin
        op      = instr_i[OP_LSB +: OP_W];
        srcs[0] = instr_i[SRCA_LSB +: REG_AW];
        srcs[1] = instr_i[SRCB_LSB +: REG_AW];
        field   = instr_i[FIELD_W-1:0];
    end

    dec_ctrl u_ctrl (
        .op_i     (op),
        .reg_we_o (c_reg_we),
        .ram_we_o (c_ram_we),
        .valid_o  (c_valid)
    );

    dec_branch u_branch (
        .op_i    (op),
        .flags_i (flags_i),
        .taken_o (br_sel_o)
    );

    dec_hazard #(.SRCS(NUM_SRC)) u_hazard (
        .ex_we_i (ctl_q.reg_we),
        .ex_wa_i (ctl_q.wr_addr),
        .src_i   (srcs),
        .fwd_o   (fwd_nxt)
    );

    // Assemble the controls headed for execute.
    always_comb begin
        ctl_nxt.alu_op  = c_valid ? op : OP_NOP;
        ctl_nxt.imm     = field;
        ctl_nxt.wr_addr = srcs[0];
        ctl_nxt.reg_we  = c_reg_we;
        ctl_nxt.ram_we  = c_ram_we;
    end

    // Decode-to-execute pipeline register; reset loads the NOP state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            fwd_q <= '0;
        end else begin
            ctl_q <= ctl_nxt;
            fwd_q <= fwd_nxt;
        end
    end

    // Drive the outputs.
    always_comb begin
        rd_addr_a_o  = srcs[0];
        rd_addr_b_o  = srcs[1];
        br_addr_o    = field;
        ex_alu_op_o  = ctl_q.alu_op;
        ex_imm_o     = ctl_q.imm;
        ex_wr_addr_o = ctl_q.wr_addr;
        ex_reg_we_o  = ctl_q.reg_we;
        ex_ram_we_o  = ctl_q.ram_we;
        ex_fwd_a_o   = fwd_q[0];
        ex_fwd_b_o   = fwd_q[1];
    end

    // R2
    reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[OP_LSB +: OP_W] >= 8'h01 && instr_i[OP_LSB +: OP_W] <= 8'h19
         && instr_i[OP_LSB +: OP_W] != 8'h0F)
        |=> ex_reg_we_o && ex_wr_addr_o == $past(instr_i[SRCA_LSB +: REG_AW]));

    // R3
    store_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ex_ram_we_o |-> !ex_reg_we_o);

    // R4
    nop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[OP_LSB +: OP_W] == 8'h00) |=> !ex_reg_we_o && !ex_ram_we_o);

    // R6
    fwd_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_reg_we_o && ex_wr_addr_o == rd_addr_a_o) |=> ex_fwd_a_o);

    // R7
    fwd_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_reg_we_o && ex_wr_addr_o == rd_addr_b_o) |=> ex_fwd_b_o);

    // R8
    no_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_reg_we_o |=> !ex_fwd_a_o && !ex_fwd_b_o);

    // R9
    jmp_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[OP_LSB +: OP_W] == 8'h21) |-> br_sel_o && br_addr_o == instr_i[FIELD_W-1:0]);
endmodule

// File: tb/dec_fwd_stage_tb.sv
module dec_fwd_stage_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] instr = 24'h01FFFF;
    logic [2:0]  flags = 3'b000;
    logic [2:0]  rd_a, rd_b, wr_addr;
    logic        br_sel, reg_we, ram_we, fwd_a, fwd_b;
    logic [9:0]  br_addr, imm;
    logic [7:0]  alu_op;

    int nchk = 0;
    int nfail = 0;
    logic       m_we = 1'b0;
    logic [2:0] m_wa = 3'd0;

    always #2.5 clk = ~clk;

    dec_fwd_stage u_dut (
        .clk(clk), .rst_n(rst_n), .instr_i(instr), .flags_i(flags),
        .rd_addr_a_o(rd_a), .rd_addr_b_o(rd_b), .br_sel_o(br_sel), .br_addr_o(br_addr),
        .ex_alu_op_o(alu_op), .ex_imm_o(imm), .ex_wr_addr_o(wr_addr),
        .ex_reg_we_o(reg_we), .ex_ram_we_o(ram_we), .ex_fwd_a_o(fwd_a), .ex_fwd_b_o(fwd_b)
    );

    // Register file and ALU model for the dependent program.
    logic [7:0] rf [8];
    logic [7:0] rda_q = 8'd0, rdb_q = 8'd0, alu_q = 8'd0;
    logic       wb_we = 1'b0;
    logic [2:0] wb_a = 3'd0;
    logic [7:0] opa, opb, alu_res;

    always_comb begin
        opa = fwd_a ? alu_q : rda_q;
        opb = fwd_b ? alu_q : rdb_q;
        case (alu_op)
            8'h01:   alu_res = opa + opb;
            8'h05:   alu_res = opa - opb;
            8'h10:   alu_res = opb;
            8'h11:   alu_res = imm[7:0];
            8'h18:   alu_res = opa + imm[7:0];
            default: alu_res = opa;
        endcase
    end

    always @(posedge clk) begin
        rda_q <= (wb_we && wb_a == rd_a) ? alu_q : rf[rd_a];
        rdb_q <= (wb_we && wb_a == rd_b) ? alu_q : rf[rd_b];
        alu_q <= alu_res;
        wb_we <= reg_we;
        wb_a  <= wr_addr;
        if (wb_we) rf[wb_a] <= alu_q;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_wr(input logic [7:0] op);
        return op >= 8'h01 && op <= 8'h19 && op != 8'h0F;
    endfunction

    function automatic logic exp_valid(input logic [7:0] op);
        return op <= 8'h1F || op == 8'h21;
    endfunction

    function automatic logic exp_br(input logic [7:0] op, input logic [2:0] f);
        case (op)
            8'h21:   return 1'b1;
            8'h1A:   return f[0];
            8'h1B:   return !f[0];
            8'h1C:   return f[2];
            8'h1D:   return !f[2];
            8'h1E:   return f[1];
            8'h1F:   return !f[1];
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [23:0] enc(input logic [7:0] op, input logic [2:0] a,
                                        input logic [2:0] b, input logic [9:0] f);
        return {op, a, b, f};
    endfunction

    // One decode cycle: drive at negedge, check combinational outputs,
    // then check the registered controls just after the rising edge.
    task automatic step(input logic [23:0] ins, input logic [2:0] fl, input bit full);
        logic [7:0] op;
        logic ea, eb;
        op = ins[23:16];
        @(negedge clk);
        instr = ins;
        flags = fl;
        #1;
        ea = m_we && (m_wa == ins[15:13]);
        eb = m_we && (m_wa == ins[12:10]);
        if (full) begin
            chk("R1", "rd_addr_a", rd_a, ins[15:13]);
            chk("R1", "rd_addr_b", rd_b, ins[12:10]);
            chk(op == 8'h21 ? "R9" : "R10", "br_sel", br_sel, exp_br(op, fl));
            if (br_sel) chk("R9", "br_addr", br_addr, ins[9:0]);
        end
        @(posedge clk);
        #1;
        if (full) begin
            chk("R2", "reg_we", reg_we, exp_wr(op));
            if (exp_wr(op)) chk("R2", "wr_addr", wr_addr, ins[15:13]);
            chk("R3", "ram_we", ram_we, op == 8'h0F);
            chk("R4", "alu_op", alu_op, exp_valid(op) ? op : 8'h00);
            chk("R5", "imm", imm, ins[9:0]);
        end
        chk(m_we ? "R6" : "R8", "fwd_a", fwd_a, ea);
        chk(m_we ? "R7" : "R8", "fwd_b", fwd_b, eb);
        m_we = exp_wr(op);
        m_wa = ins[15:13];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = 8'd0;
        // R11: reset with a register-writing, forwarding-prone word applied.
        repeat (3) @(posedge clk);
        #1;
        chk("R11", "reg_we", reg_we, 0);
        chk("R11", "ram_we", ram_we, 0);
        chk("R11", "alu_op", alu_op, 0);
        chk("R11", "imm", imm, 0);
        chk("R11", "wr_addr", wr_addr, 0);
        chk("R11", "fwd_a", fwd_a, 0);
        chk("R11", "fwd_b", fwd_b, 0);
        @(negedge clk);
        instr = 24'h0;
        rst_n = 1'b1;

        // Opcode sweep: every opcode against every flag setting.
        for (int op = 0; op < 256; op++) begin
            for (int f = 0; f < 8; f++) begin
                step(enc(8'(op), 3'(op ^ f), 3'(f), {3'(f), 7'(op)}), 3'(f), 1'b1);
            end
        end

        // Forwarding sweep: writer (ADD) or non-writer (STORE) then all sources.
        for (int w = 0; w < 2; w++) begin
            for (int d = 0; d < 8; d++) begin
                for (int a = 0; a < 8; a++) begin
                    for (int b = 0; b < 8; b++) begin
                        step(enc(w ? 8'h01 : 8'h0F, 3'(d), 3'(7 - d), 10'h0), 3'd0, 1'b0);
                        step(enc(8'h05, 3'(a), 3'(b), 10'(a * 8 + b)), 3'd0, 1'b1);
                    end
                end
            end
        end

        // Dependent program through the bench register file and ALU.
        for (int i = 0; i < 3; i++) step(24'h0, 3'd0, 1'b0);
        step(enc(8'h11, 3'd0, 3'd0, 10'd5), 3'd0, 1'b0);  // mvi r0,5
        step(enc(8'h11, 3'd1, 3'd0, 10'd3), 3'd0, 1'b0);  // mvi r1,3
        step(enc(8'h01, 3'd0, 3'd1, 10'd0), 3'd0, 1'b0);  // add r0,r1 (B fwd)
        step(enc(8'h01, 3'd0, 3'd1, 10'd0), 3'd0, 1'b0);  // add r0,r1 (A fwd)
        step(enc(8'h05, 3'd0, 3'd1, 10'd0), 3'd0, 1'b0);  // sub r0,r1
        step(enc(8'h10, 3'd2, 3'd0, 10'd0), 3'd0, 1'b0);  // mov r2,r0
        step(enc(8'h18, 3'd2, 3'd0, 10'd4), 3'd0, 1'b0);  // addi r2,4
        step(enc(8'h11, 3'd3, 3'd0, 10'd7), 3'd0, 1'b0);  // mvi r3,7
        step(24'h0, 3'd0, 1'b0);                          // nop
        step(enc(8'h18, 3'd3, 3'd0, 10'd1), 3'd0, 1'b0);  // addi r3,1 (bypass)
        for (int i = 0; i < 4; i++) step(24'h0, 3'd0, 1'b0);
        chk("R6", "r0 after forwarded chain", rf[0], 8);
        chk("R7", "r1 loaded", rf[1], 3);
        chk("R7", "r2 via B then A forward", rf[2], 12);
        chk("R8", "r3 distance-two", rf[3], 8);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule